// File: doc/BRIEF.md
# BCD Up/Down Digit Counter with Separate Count Strobes

This block is one decimal digit of a counter that counts in 8421 BCD from 0 to 9. It has two count strobes, one for counting up and one for counting down. A rising edge on the up strobe adds one to the digit, and a rising edge on the down strobe subtracts one. A master clear sets the digit to zero. A parallel preset, loaded while an active-low load pin is held low, sets the digit to any 4-bit value.

The block runs on one free-running system clock. Each strobe passes through a synchronizer, and a rising edge is found by comparing the synchronized level with its value one clock earlier. Clear and load are sampled on the same clock. The digit has two active-low outputs. The carry output copies the low phase of the up strobe while the digit reads 9, and the borrow output copies the low phase of the down strobe while the digit reads 0. These outputs can drive the up and down strobes of the next digit directly, so a multi-digit counter needs no glue logic. There is no streaming data path, so every pin is a plain level signal.

Top module: `bcd_updn_digit`

## Requirements
- R1: When the synchronized up strobe rises and the down strobe does not rise in the same cycle, the digit `q` (4-bit binary 8421 value) increments by one, and 9 wraps to 0.
- R2: When the synchronized down strobe rises and the up strobe does not rise in the same cycle, `q` decrements by one, and 0 wraps to 9.
- R3: When `rst_n` is low, or `clr` is high at a clock edge, `q` becomes 0. `clr` takes priority over `load_n` and over both strobes.
- R4: When `clr` is low and `load_n` is low at a clock edge, `q` takes the value of `preset`. Strobe edges in that cycle are ignored.
- R5: When `clr` is low, `load_n` is high and no strobe edge is detected, `q` holds its value.
- R6: `carry_n` is 0 exactly when `q` is 9 and the synchronized up strobe is low. Otherwise it is 1.
- R7: `borrow_n` is 0 exactly when `q` is 0 and the synchronized down strobe is low. Otherwise it is 1.
- R8: A strobe that is low during a clear or a load and stays low afterwards is counted on its next rising edge.
- R9: An illegal value from 10 to 15, placed by a load, goes to 0 on an up count and to 9 on a down count, with no carry or borrow pulse.
- R10: When rising edges on both strobes are detected in the same cycle, `q` holds its value.
- R11: A strobe edge that arrives between two clock edges changes `q` at the third clock edge after it. A strobe held high produces only one count.
- R12: Two digits chained (carry to up, borrow to down) count as a two-digit decimal counter from 00 to 99, wrapping in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| clr | input | 1 | Master clear, active high, sampled on `clk` |
| load_n | input | 1 | Preset load, active low, sampled on `clk` |
| preset | input | 4 | Value loaded into the digit |
| up_in | input | 1 | Count-up strobe, counted on its rising edge |
| dn_in | input | 1 | Count-down strobe, counted on its rising edge |
| q | output | 4 | Current digit, 8421 BCD |
| carry_n | output | 1 | Active-low carry, follows the low phase of `up_in` at 9 |
| borrow_n | output | 1 | Active-low borrow, follows the low phase of `dn_in` at 0 |

## Verification
The hardest cases to reach from the ports are a strobe that goes low during a clear or load and rises only after it, and the wrap of a chained pair across 99/00, where the upper digit counts on a carry edge that the lower digit makes itself. The bench forces these with directed sequences that hold a strobe low across a clear or a load, and that preset both digits to 9 or to 0 before a pulse. It also lowers both strobes and raises them on the same clock to reach the simultaneous-edge hold. Constrained random pulses, loads (including illegal values) and clears then run through two chained instances, checked against a two-digit model in the bench.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;

  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned DIGIT_MAX = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  // Strobe channel indices inside the top-level arrays.
  localparam int unsigned CH_UP = 0;
  localparam int unsigned CH_DN = 1;
  localparam int unsigned N_CH  = 2;

  function automatic digit_t digit_inc(input digit_t v);
    if (v >= digit_t'(DIGIT_MAX)) return '0;
    return v + digit_t'(1);
  endfunction

  function automatic digit_t digit_dec(input digit_t v);
    if (v == '0 || v > digit_t'(DIGIT_MAX)) return digit_t'(DIGIT_MAX);
    return v - digit_t'(1);
  endfunction

endpackage

// File: rtl/bcd_edge_sync.sv
module bcd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign level = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= level;
  end

  assign rise = level & ~prev;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R11

endmodule

// File: rtl/bcd_digit_reg.sv
module bcd_digit_reg
  import bcd_digit_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   load_n,
  input  digit_t preset,
  input  logic   up_rise,
  input  logic   dn_rise,
  output digit_t q
);

  step_e step;

  always_comb begin
    step = STEP_NONE;
    if (up_rise && !dn_rise)      step = STEP_UP;
    else if (dn_rise && !up_rise) step = STEP_DN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (clr) begin
      q <= '0;
    end else if (!load_n) begin
      q <= preset;
    end else begin
      unique case (step)
        STEP_UP: q <= digit_inc(q);
        STEP_DN: q <= digit_dec(q);
        default: q <= q;
      endcase
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0)); // R3
  AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> (q == $past(preset))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && !up_rise && !dn_rise) |=> $stable(q)); // R5
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && up_rise && dn_rise) |=> $stable(q)); // R10
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && up_rise && !dn_rise && q == digit_t'(DIGIT_MAX)) |=> (q == '0)); // R1
  AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && dn_rise && !up_rise && q == '0) |=> (q == digit_t'(DIGIT_MAX))); // R2
  AST_ILLEGAL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && up_rise && !dn_rise && q > digit_t'(DIGIT_MAX)) |=> (q == '0)); // R9

endmodule

// File: rtl/bcd_term_detect.sv
module bcd_term_detect
  import bcd_digit_pkg::*;
(
  input  digit_t q,
  input  logic   up_level,
  input  logic   dn_level,
  output logic   carry_n,
  output logic   borrow_n
);

  logic at_max;
  logic at_zero;

  assign at_max   = (q == digit_t'(DIGIT_MAX));
  assign at_zero  = (q == '0);
  assign carry_n  = ~(at_max  & ~up_level);
  assign borrow_n = ~(at_zero & ~dn_level);

endmodule

// File: rtl/bcd_updn_digit.sv
module bcd_updn_digit
  import bcd_digit_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               load_n,
  input  logic [DIGIT_W-1:0] preset,
  input  logic               up_in,
  input  logic               dn_in,
  output logic [DIGIT_W-1:0] q,
  output logic               carry_n,
  output logic               borrow_n
);

  logic [N_CH-1:0] strobe_raw;
  logic [N_CH-1:0] strobe_lvl;
  logic [N_CH-1:0] strobe_rise;

  assign strobe_raw[CH_UP] = up_in;
  assign strobe_raw[CH_DN] = dn_in;

  generate
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
      bcd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (strobe_raw[ch]),
        .level (strobe_lvl[ch]),
        .rise  (strobe_rise[ch])
      );
    end
  endgenerate

  bcd_digit_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .load_n  (load_n),
    .preset  (preset),
    .up_rise (strobe_rise[CH_UP]),
    .dn_rise (strobe_rise[CH_DN]),
    .q       (q)
  );

  bcd_term_detect u_term (
    .q        (q),
    .up_level (strobe_lvl[CH_UP]),
    .dn_level (strobe_lvl[CH_DN]),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

  // A carry release at 9 must be followed by the wrap to 0 (cascade hand-off).
  AST_CARRY_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && $rose(carry_n) && q == DIGIT_W'(DIGIT_MAX) && !strobe_rise[CH_DN])
      |=> (q == '0)); // R6
  AST_BORROW_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && $rose(borrow_n) && q == '0 && !strobe_rise[CH_UP])
      |=> (q == DIGIT_W'(DIGIT_MAX))); // R7

endmodule

// File: tb/sim_bcd_updn_digit.sv
`timescale 1ns/1ps
module sim_bcd_updn_digit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] pre_lo = 4'd0;
  logic [3:0] pre_hi = 4'd0;
  logic       up_in = 1'b1;
  logic       dn_in = 1'b1;
  logic [3:0] q_lo, q_hi;
  logic       carry_lo, borrow_lo, carry_hi, borrow_hi;

  int total = 0;
  int bad = 0;
  int lo = 0;
  int hi = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_updn_digit u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .preset(pre_lo),
    .up_in(up_in), .dn_in(dn_in), .q(q_lo), .carry_n(carry_lo), .borrow_n(borrow_lo)
  );

  bcd_updn_digit u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .preset(pre_hi),
    .up_in(carry_lo), .dn_in(borrow_lo), .q(q_hi), .carry_n(carry_hi), .borrow_n(borrow_hi)
  );

  function automatic int m_up(input int v);
    return (v >= 9) ? 0 : v + 1;
  endfunction

  function automatic int m_dn(input int v);
    return (v == 0 || v > 9) ? 9 : v - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_digits(input string req);
    chk({req, " low digit"}, int'(q_lo), lo);
    chk({req, " high digit"}, int'(q_hi), hi);
  endtask

  task automatic pulse_up();
    up_in = 1'b0;
    cyc(4);
    chk("R6 carry_n in low phase", int'(carry_lo), (lo == 9) ? 0 : 1);
    chk("R7 borrow_n idle", int'(borrow_lo), 1);
    up_in = 1'b1;
    cyc(7);
    if (lo == 9) hi = m_up(hi);
    lo = m_up(lo);
    chk_digits("R1 R12 up count");
  endtask

  task automatic pulse_dn();
    dn_in = 1'b0;
    cyc(4);
    chk("R7 borrow_n in low phase", int'(borrow_lo), (lo == 0) ? 0 : 1);
    chk("R6 carry_n idle", int'(carry_lo), 1);
    dn_in = 1'b1;
    cyc(7);
    if (lo == 0) hi = m_dn(hi);
    lo = m_dn(lo);
    chk_digits("R2 R12 down count");
  endtask

  task automatic do_load(input int l, input int h);
    pre_lo = 4'(l);
    pre_hi = 4'(h);
    load_n = 1'b0;
    cyc(2);
    load_n = 1'b1;
    cyc(1);
    lo = l;
    hi = h;
    chk_digits("R4 load");
  endtask

  task automatic do_clr();
    clr = 1'b1;
    cyc(2);
    clr = 1'b0;
    cyc(1);
    lo = 0;
    hi = 0;
    chk_digits("R3 clear");
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R3 reset state
    chk_digits("R3 reset");
    chk("R3 reset carry_n", int'(carry_lo), 1);
    chk("R3 reset borrow_n", int'(borrow_lo), 1);

    // R11 latency: q changes at the third clock edge after the strobe rises
    up_in = 1'b0;
    cyc(4);
    up_in = 1'b1;
    cyc(1);
    chk("R11 edge1 no change", int'(q_lo), 0);
    cyc(1);
    chk("R11 edge2 no change", int'(q_lo), 0);
    cyc(1);
    chk("R11 edge3 counted", int'(q_lo), 1);
    cyc(4);
    chk("R11 single count for held strobe", int'(q_lo), 1);
    lo = 1;

    // R12 up wrap across 99
    do_load(9, 9);
    pulse_up();
    chk("R12 99 up wraps to 00", int'(q_hi) * 10 + int'(q_lo), 0);
    // R2 R7 R12 down wrap across 00
    pulse_dn();
    chk("R12 00 down wraps to 99", int'(q_hi) * 10 + int'(q_lo), 99);
    do_load(0, 3);
    pulse_dn();

    // R10 both edges in the same cycle
    do_load(5, 1);
    up_in = 1'b0;
    dn_in = 1'b0;
    cyc(4);
    up_in = 1'b1;
    dn_in = 1'b1;
    cyc(7);
    chk_digits("R10 simultaneous edges hold");

    // R4 strobe edges ignored while load is held
    pre_lo = 4'd3;
    pre_hi = 4'd2;
    load_n = 1'b0;
    up_in = 1'b0;
    cyc(4);
    up_in = 1'b1;
    cyc(6);
    lo = 3;
    hi = 2;
    chk_digits("R4 count ignored during load");
    load_n = 1'b1;
    cyc(3);
    chk_digits("R4 after load release");

    // R3 clear beats load
    pre_lo = 4'd7;
    clr = 1'b1;
    load_n = 1'b0;
    cyc(3);
    lo = 0;
    hi = 0;
    chk_digits("R3 clear over load");
    clr = 1'b0;
    load_n = 1'b1;
    cyc(2);
    chk_digits("R5 idle hold");

    // R8 strobe low across a load, then counted
    up_in = 1'b0;
    pre_lo = 4'd4;
    pre_hi = 4'd6;
    load_n = 1'b0;
    cyc(3);
    load_n = 1'b1;
    cyc(3);
    up_in = 1'b1;
    cyc(7);
    lo = 5;
    hi = 6;
    chk_digits("R8 edge after load counted");

    // R8 strobe low across a clear, then counted (borrows into high digit)
    dn_in = 1'b0;
    clr = 1'b1;
    cyc(3);
    clr = 1'b0;
    cyc(3);
    dn_in = 1'b1;
    cyc(7);
    lo = 9;
    hi = 9;
    chk_digits("R8 edge after clear counted");

    // R9 illegal values
    do_load(12, 4);
    pulse_up();
    chk("R9 illegal up goes to 0", int'(q_lo), 0);
    chk("R9 no carry from illegal", int'(q_hi), 4);
    do_load(14, 4);
    pulse_dn();
    chk("R9 illegal down goes to 9", int'(q_lo), 9);
    chk("R9 no borrow from illegal", int'(q_hi), 4);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 19));
      if (op < 8)       pulse_up();
      else if (op < 16) pulse_dn();
      else if (op < 19) do_load(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
      else              do_clr();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule